// File: doc/BRIEF.md
# Saturating Periodic Tick Counter

This block divides the system clock down to a fixed 300 Hz event rate. Each event raises an interrupt request and adds one to a four-bit count of events that software has not yet serviced. Software reads that count through an 8-bit I/O port decode. The read returns the count in the low nibble and clears it in the same access, so software can tell how many ticks it missed since its last visit.

The count stops at fifteen instead of wrapping. A long stall in software therefore reads as "fifteen or more" and never as a small, misleading number. The interrupt request stays high until software reads the count.

Top module: `periodic_tick_ctr`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rdData` is 0 and `irq` is 0. The missed-tick count starts at 0.
- R2: A one-cycle internal tick occurs once every `CLK_HZ/TICK_HZ` clock cycles. The first tick falls in the cycle that ends the `CLK_HZ/TICK_HZ`-th rising edge after reset is released.
- R3: A tick with no read in the same cycle adds one to the count at the next edge, unless the count is already 15.
- R4: Once the count reaches 15, further ticks leave it at 15.
- R5: A read is `ioRd` high with `portAddr` equal to `READ_PORT` (default 8'hF4). In that cycle `rdData` carries the current count combinationally, and the count becomes 0 at the next edge.
- R6: `ioRd` high with any other `portAddr` gives `rdData` 0 and leaves both the count and `irq` unchanged.
- R7: A read in the same cycle as a tick returns the old count, and the count becomes 1 at the next edge.
- R8: `irq` goes high at the edge that ends a tick cycle. It stays high until a read, and it falls at the edge ending that read, unless a tick falls in the same cycle as the read.
- R9: With `ioRd` low, `rdData` is 0 and `portAddr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioRd | input | 1 | I/O read strobe |
| portAddr | input | 8 | Low byte of the I/O port address |
| rdData | output | 4 | Missed-tick count during a decoded read, else 0 |
| irq | output | 1 | Timer interrupt request |

## Verification
The following are checked by assertions on every cycle:
- the tick is a single-cycle pulse;
- the count holds at 15 when there is no read;
- the count steps by one per unread tick;
- the count clears after a read;
- the count becomes 1 when a read meets a tick;
- `irq` stays high without a read.

Some behaviour can only be shown by the bench's scenarios, because it depends on absolute timing or on the port decode. These are:
- the exact cycle of each tick measured from reset;
- that a foreign port address leaves all state untouched;
- the value seen on `rdData` while a read is in progress;
- the sequence of a long stall that saturates the count, followed by a read.

// File: rtl/periodic_tick_pkg.sv
package periodic_tick_pkg;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef struct packed {
    logic incr;   // unread tick, count may advance
    logic clear;  // read without tick
    logic load1;  // read and tick together
  } tick_strobes_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 300
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int DIV   = (CLK_HZ / TICK_HZ < 2) ? 2 : CLK_HZ / TICK_HZ;
  localparam int DIV_W = $clog2(DIV);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  // R2: a tick lasts one cycle and restarts the period
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (!tick && phase == '0));
endmodule

// File: rtl/tick_control.sv
module tick_control
  import periodic_tick_pkg::*;
#(
  parameter logic [7:0] READ_PORT = 8'hF4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          ioRd,
  input  logic [7:0]    portAddr,
  output logic          readHit,
  output tick_strobes_t strobes,
  output logic          irq
);
  assign readHit = ioRd && (portAddr == READ_PORT);

  always_comb begin
    strobes       = '0;
    strobes.load1 = readHit && tick;
    strobes.clear = readHit && !tick;
    strobes.incr  = tick && !readHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        irq <= 1'b0;
    else if (tick)    irq <= 1'b1;
    else if (readHit) irq <= 1'b0;
  end

  // R8: request holds until serviced by a read
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !readHit) |=> irq);
  // R8: a tick always leaves the request raised
  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> irq);
  // strobes are mutually exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.incr, strobes.clear, strobes.load1}));
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import periodic_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tick_strobes_t    strobes,
  input  logic             readHit,
  output logic [CNT_W-1:0] rdData
);
  logic [CNT_W-1:0] count;
  logic             atMax;

  assign atMax = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       count <= '0;
    else if (strobes.load1)          count <= CNT_W'(1);
    else if (strobes.clear)          count <= '0;
    else if (strobes.incr && !atMax) count <= count + 1'b1;
  end

  assign rdData = readHit ? count : '0;

  // R4: saturated count holds without a read
  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && !readHit) |=> atMax);
  // R3: unread tick below max steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incr && !atMax) |=> (count == $past(count) + 1'b1));
  // R5: plain read clears
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (count == '0));
  // R7: read meeting tick leaves one
  p_collide_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load1 |=> (count == CNT_W'(1)));
  // R6/R9: no read, no tick keeps count
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.incr || strobes.clear || strobes.load1) |=> $stable(count));
endmodule

// File: rtl/periodic_tick_ctr.sv
module periodic_tick_ctr
  import periodic_tick_pkg::*;
#(
  parameter int         CLK_HZ    = 50_000_000,
  parameter int         TICK_HZ   = 300,
  parameter logic [7:0] READ_PORT = 8'hF4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioRd,
  input  logic [7:0] portAddr,
  output logic [3:0] rdData,
  output logic       irq
);
  logic          tick;
  logic          readHit;
  tick_strobes_t strobes;

  tick_prescaler #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_prescaler (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  tick_control #(.READ_PORT(READ_PORT)) u_control (
    .clk(clk), .rstN(rstN), .tick(tick), .ioRd(ioRd), .portAddr(portAddr),
    .readHit(readHit), .strobes(strobes), .irq(irq)
  );

  tick_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .readHit(readHit),
    .rdData(rdData)
  );
endmodule

// File: tb/periodic_tick_ctr_bench.sv
module periodic_tick_ctr_bench;
  localparam int CLK_HZ  = 3000;
  localparam int TICK_HZ = 300;
  localparam int DIV     = CLK_HZ / TICK_HZ;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioRd = 1'b0;
  logic [7:0] portAddr = 8'h00;
  logic [3:0] rdData;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  int mPhase = 0;
  int mCount = 0;
  bit mIrq = 0;

  periodic_tick_ctr #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_periodic_tick_ctr (
    .clk(clk), .rstN(rstN), .ioRd(ioRd), .portAddr(portAddr),
    .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCount = 0; mIrq = 0;
    end else begin
      bit tickNow, hit;
      tickNow = (mPhase == DIV - 1);
      hit = ioRd && (portAddr == 8'hF4);
      if (hit && tickNow)            mCount = 1;
      else if (hit)                  mCount = 0;
      else if (tickNow && mCount < 15) mCount = mCount + 1;
      if (tickNow)  mIrq = 1;
      else if (hit) mIrq = 0;
      mPhase = (mPhase + 1) % DIV;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic compare(input string tag);
    int expData;
    expData = (ioRd && portAddr == 8'hF4) ? mCount : 0;
    checks++;
    if (rdData !== 4'(expData) || irq !== mIrq) begin
      failures++;
      $display("FAIL %s rdData=%0d irq=%0b expected rdData=%0d irq=%0b",
               tag, rdData, irq, expData, mIrq);
    end
  endtask

  task automatic step(input bit rd, input logic [7:0] addr, input string tag);
    @(negedge clk);
    ioRd = rd;
    portAddr = addr;
    #1;
    compare(tag);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 compare("R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    #1 compare("R1 after release");

    // R2/R3/R8: idle through two ticks, cycle-exact
    for (int i = 0; i < 2 * DIV + 3; i++) step(1'b0, 8'h00, "R2 R3 R8 idle ticks");

    // R9: strobe low with matching address has no effect
    for (int i = 0; i < 3; i++) step(1'b0, 8'hF4, "R9 strobe low");

    // R5: decoded read returns and clears
    step(1'b1, 8'hF4, "R5 read");
    step(1'b0, 8'h00, "R5 after read");
    step(1'b1, 8'hF4, "R5 reread zero");

    // R6: foreign ports
    for (int i = 0; i < DIV + 2; i++) step(1'b1, 8'hF5, "R6 foreign port");
    step(1'b1, 8'h74, "R6 foreign port high bit");
    step(1'b1, 8'hF4, "R6 count kept");

    // R4: stall long enough to saturate
    for (int i = 0; i < 18 * DIV; i++) step(1'b0, 8'h00, "R4 saturate");
    step(1'b1, 8'hF4, "R4 read saturated");
    step(1'b0, 8'h00, "R4 cleared");

    // R7: read colliding with a tick
    while (mPhase != DIV - 1) step(1'b0, 8'h00, "R7 align");
    step(1'b1, 8'hF4, "R7 collide read");
    step(1'b0, 8'h00, "R7 irq kept");
    step(1'b1, 8'hF4, "R7 count one");

    // R8: read right after a tick lowers irq
    while (mPhase != 0) step(1'b0, 8'h00, "R8 align");
    step(1'b0, 8'h00, "R8 irq raised");
    step(1'b1, 8'hF4, "R8 service");
    step(1'b0, 8'h00, "R8 irq lowered");

    // R1: reset mid-run clears state
    for (int i = 0; i < DIV; i++) step(1'b0, 8'h00, "R3 refill");
    @(negedge clk);
    rstN = 1'b0;
    #1 compare("R1 reset again");
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < DIV + 2; i++) step(1'b0, 8'h00, "R2 period after reset");
    step(1'b1, 8'hF4, "R2 one tick after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule